// File: doc/BRIEF.md
# Speculative Store Queue

This block holds stores between the point where they issue and the point where they write into the data cache. A store takes one slot at issue, in program order, and is told the slot number. The address (with an access size) and the data then arrive through two independent write ports, in whichever order the execution units produce them. A retire pulse marks the oldest speculative store of a thread as committed to happen. A flush pulse discards everything a thread still holds speculatively. Retired stores leave one at a time, oldest first, through a valid/ready write channel towards the cache.

The slots form a ring with head, retire and tail pointers. When two hardware threads run, the ring is cut into two equal rings, one per thread. Each thread gets a drained flag that a fence or atomic sequence can wait on before letting younger loads proceed.

The write channel follows valid/ready rules. `cw_valid` rises only when the granted thread's oldest store is retired and has both halves. While `cw_ready` is low, the offered store and its byte mask stay unchanged. The store leaves on the cycle where both are high. Back-pressure never loses or reorders a store: retirement and allocation continue while the channel is stalled, until the ring fills.

Top module: `store_queue`

## Requirements
- R1: In unified mode, accepted allocations receive slot numbers 0, 1, 2 … DEPTH-1 and then wrap to 0. The slot number is shown on `alloc_idx` in the cycle of acceptance.
- R2: `alloc_ready` is low when the addressed thread already holds as many stores as its ring has slots, whatever their sizes. It is also low when a flush for that same thread is presented in the same cycle. Otherwise it is high.
- R3: Address and data are written by slot number in either order. The store offered for commit carries the last address and data written to that slot.
- R4: `cw_valid` is high only when the oldest store of the granted thread is retired and has both address and data. An older store that is not ready blocks every younger store of its thread.
- R5: A retire pulse marks the oldest non-retired store of its thread. A retire pulse while the thread has no non-retired store has no effect.
- R6: A flush drops every non-retired store of its thread. Retired stores stay and still commit. A retire and a flush for the same thread in one cycle apply the retire first.
- R7: While `cw_valid` is high and `cw_ready` is low, `cw_tid`, `cw_addr`, `cw_data` and `cw_be` stay stable. A store leaves the queue when `cw_valid` and `cw_ready` are both high.
- R8: Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. `cw_be` sets that many consecutive bits starting at the byte lane given by the low address bits (bits 2:0 for 64-bit data). The data is passed through lane-aligned.
- R9: In split mode, thread 0 uses slots 0 to HALF-1 and thread 1 uses slots HALF to 2·HALF-1, where HALF = DEPTH/2 rounded down. Each half is its own ring. In unified mode the thread fields are ignored and everything belongs to thread 0.
- R10: `drained[t]` is high when thread t holds no store. In unified mode both bits show the single ring.
- R11: When both threads have a ready store, the thread that did not complete the last handshake is offered first. The choice is held while a store is stalled.
- R12: `split_en` may change only while both threads are drained. During the cycle in which it differs from the mode in force, allocation is refused. Afterwards each ring restarts at its base slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_en | input | 1 | 1 = two threads with half the slots each |
| alloc_valid | input | 1 | Store issue request |
| alloc_tid | input | 1 | Issuing thread |
| alloc_ready | output | 1 | Slot available, request accepted |
| alloc_idx | output | IDX_W | Slot given to the issuing store |
| addr_we | input | 1 | Address write strobe |
| addr_idx | input | IDX_W | Slot receiving the address |
| addr_val | input | ADDR_W | Store address |
| addr_size | input | 2 | Size code |
| data_we | input | 1 | Data write strobe |
| data_idx | input | IDX_W | Slot receiving the data |
| data_val | input | DATA_W | Lane-aligned store data |
| retire_valid | input | 1 | Retire pulse |
| retire_tid | input | 1 | Retiring thread |
| flush_valid | input | 1 | Misspeculation flush pulse |
| flush_tid | input | 1 | Flushed thread |
| cw_valid | output | 1 | Cache write offered |
| cw_ready | input | 1 | Cache write port accepts |
| cw_tid | output | 1 | Thread of offered store |
| cw_addr | output | ADDR_W | Address of offered store |
| cw_data | output | DATA_W | Data of offered store |
| cw_be | output | DATA_W/8 | Byte-enable mask |
| drained | output | 2 | Per-thread empty flags |

## Verification
The bench builds the queue with DEPTH = 8, 32-bit addresses and 64-bit data. In split mode each ring therefore has 4 slots, so random traffic reaches the full ring, pointer wrap, flushes that rewind the tail across the wrap point, and contention between the two threads within a few dozen cycles. The bench runs in unified mode, switches to split mode, and switches back. This exercises both ring geometries and the restart at the base slots.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int NUM_THREADS = 2;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } sq_size_e;
endpackage

// File: rtl/sq_ring_ctrl.sv
module sq_ring_ctrl #(
  parameter int IDX_W = 6,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [IDX_W-1:0] base,
  input  logic [CNT_W-1:0] size,
  input  logic             push,
  input  logic             retire,
  input  logic             flush,
  input  logic             pop,
  output logic [IDX_W-1:0] tail_phys,
  output logic [IDX_W-1:0] head_phys,
  output logic             full,
  output logic             empty,
  output logic             head_retired
);
  typedef logic [IDX_W:0] ptr_t;

  ptr_t head_q, ret_q, tail_q;
  ptr_t ret_n, tail_n;

  // Advance within a ring of runtime length sz; the top bit flips on wrap.
  function automatic ptr_t bump(input ptr_t p, input logic [CNT_W-1:0] sz);
    if (CNT_W'(p[IDX_W-1:0]) + CNT_W'(1) == sz)
      return {~p[IDX_W], {IDX_W{1'b0}}};
    return {p[IDX_W], p[IDX_W-1:0] + IDX_W'(1)};
  endfunction

  always_comb begin
    ret_n = ret_q;
    if (retire && (ret_q != tail_q)) ret_n = bump(ret_q, size);
    tail_n = tail_q;
    if (flush)     tail_n = ret_n;
    else if (push) tail_n = bump(tail_q, size);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      ret_q  <= '0;
      tail_q <= '0;
    end else if (clear) begin
      head_q <= '0;
      ret_q  <= '0;
      tail_q <= '0;
    end else begin
      if (pop) head_q <= bump(head_q, size);
      ret_q  <= ret_n;
      tail_q <= tail_n;
    end
  end

  assign empty        = (head_q == tail_q);
  assign full         = (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]) &&
                        (head_q[IDX_W] != tail_q[IDX_W]);
  assign head_retired = (head_q != ret_q);
  assign tail_phys    = base + tail_q[IDX_W-1:0];
  assign head_phys    = base + head_q[IDX_W-1:0];
endmodule

// File: rtl/sq_entry_store.sv
module sq_entry_store #(
  parameter int DEPTH  = 56,
  parameter int IDX_W  = 6,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic              addr_we,
  input  logic [IDX_W-1:0]  addr_idx,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic [1:0]        addr_size,
  input  logic              data_we,
  input  logic [IDX_W-1:0]  data_idx,
  input  logic [DATA_W-1:0] data_val,
  input  logic [IDX_W-1:0]  head_idx0,
  input  logic [IDX_W-1:0]  head_idx1,
  output logic [1:0]        head_ok,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_size,
  output logic [DATA_W-1:0] rd_data
);
  logic [DEPTH-1:0] addr_ok;
  logic [DEPTH-1:0] data_ok;
  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [1:0]        size_mem [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];

  // Per-slot halves-present flags; allocation clears, each write port sets.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_ok <= '0;
      data_ok <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (alloc_en && (alloc_idx == IDX_W'(e))) begin
          addr_ok[e] <= 1'b0;
          data_ok[e] <= 1'b0;
        end
        if (addr_we && (addr_idx == IDX_W'(e))) addr_ok[e] <= 1'b1;
        if (data_we && (data_idx == IDX_W'(e))) data_ok[e] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (addr_we) begin
      addr_mem[addr_idx] <= addr_val;
      size_mem[addr_idx] <= addr_size;
    end
    if (data_we) data_mem[data_idx] <= data_val;
  end

  assign head_ok[0] = addr_ok[head_idx0] & data_ok[head_idx0];
  assign head_ok[1] = addr_ok[head_idx1] & data_ok[head_idx1];
  assign rd_addr    = addr_mem[rd_idx];
  assign rd_size    = size_mem[rd_idx];
  assign rd_data    = data_mem[rd_idx];
endmodule

// File: rtl/sq_commit_port.sv
module sq_commit_port #(
  parameter int LANES = 8,
  parameter int OFF_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cand,
  input  logic             cw_ready,
  input  logic [OFF_W-1:0] sel_off,
  input  logic [1:0]       sel_size,
  output logic             gnt,
  output logic             cw_valid,
  output logic [1:0]       pop,
  output logic [LANES-1:0] be
);
  logic held_q, grant_q, prio_q;

  always_comb begin
    if (held_q)            gnt = grant_q;
    else if (cand[prio_q]) gnt = prio_q;
    else                   gnt = ~prio_q;
  end

  assign cw_valid = cand[gnt];
  assign pop[0]   = cw_valid & cw_ready & ~gnt;
  assign pop[1]   = cw_valid & cw_ready &  gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      grant_q <= 1'b0;
      prio_q  <= 1'b0;
    end else begin
      held_q  <= cw_valid & ~cw_ready;
      grant_q <= gnt;
      if (cw_valid && cw_ready) prio_q <= ~gnt;
    end
  end

  always_comb begin
    int lo;
    int hi;
    lo = int'(sel_off);
    hi = lo + (1 << sel_size);
    for (int b = 0; b < LANES; b++) be[b] = (b >= lo) && (b < hi);
  end
endmodule

// File: rtl/store_queue.sv
module store_queue
  import sq_pkg::*;
#(
  parameter int DEPTH  = 56,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              split_en,
  input  logic              alloc_valid,
  input  logic              alloc_tid,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              addr_we,
  input  logic [IDX_W-1:0]  addr_idx,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic [1:0]        addr_size,
  input  logic              data_we,
  input  logic [IDX_W-1:0]  data_idx,
  input  logic [DATA_W-1:0] data_val,
  input  logic              retire_valid,
  input  logic              retire_tid,
  input  logic              flush_valid,
  input  logic              flush_tid,
  output logic              cw_valid,
  input  logic              cw_ready,
  output logic              cw_tid,
  output logic [ADDR_W-1:0] cw_addr,
  output logic [DATA_W-1:0] cw_data,
  output logic [LANES-1:0]  cw_be,
  output logic [1:0]        drained
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int HALF  = DEPTH / 2;
  localparam int OFF_W = $clog2(LANES);

  logic mode_q, mode_chg;
  logic a_tid, r_tid, f_tid;
  logic [NUM_THREADS-1:0] push, ret, fl, pop, full, empty, hret, cand, head_ok;
  logic [IDX_W-1:0] tail_phys [NUM_THREADS];
  logic [IDX_W-1:0] head_phys [NUM_THREADS];
  logic [IDX_W-1:0] rd_idx;
  logic [1:0]       rd_size;
  logic             gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= split_en;
  end
  assign mode_chg = mode_q ^ split_en;

  // Thread fields only count in split mode.
  assign a_tid = mode_q & alloc_tid;
  assign r_tid = mode_q & retire_tid;
  assign f_tid = mode_q & flush_tid;

  assign alloc_ready = !mode_chg && !full[a_tid] && !fl[a_tid];
  assign alloc_idx   = tail_phys[a_tid];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_ring
    localparam logic [IDX_W-1:0] BASE = (t == 0) ? {IDX_W{1'b0}} : IDX_W'(HALF);
    logic [CNT_W-1:0] ring_size;

    assign ring_size = (t == 0 && !mode_q) ? CNT_W'(DEPTH) : CNT_W'(HALF);
    assign push[t]   = alloc_valid && alloc_ready && (a_tid == 1'(t));
    assign ret[t]    = retire_valid && (r_tid == 1'(t));
    assign fl[t]     = flush_valid && (f_tid == 1'(t));
    assign cand[t]   = hret[t] & head_ok[t];

    sq_ring_ctrl #(
      .IDX_W(IDX_W),
      .CNT_W(CNT_W)
    ) u_ring (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (mode_chg),
      .base        (BASE),
      .size        (ring_size),
      .push        (push[t]),
      .retire      (ret[t]),
      .flush       (fl[t]),
      .pop         (pop[t]),
      .tail_phys   (tail_phys[t]),
      .head_phys   (head_phys[t]),
      .full        (full[t]),
      .empty       (empty[t]),
      .head_retired(hret[t])
    );
  end

  sq_entry_store #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_en (alloc_valid && alloc_ready),
    .alloc_idx(alloc_idx),
    .addr_we  (addr_we),
    .addr_idx (addr_idx),
    .addr_val (addr_val),
    .addr_size(addr_size),
    .data_we  (data_we),
    .data_idx (data_idx),
    .data_val (data_val),
    .head_idx0(head_phys[0]),
    .head_idx1(head_phys[1]),
    .head_ok  (head_ok),
    .rd_idx   (rd_idx),
    .rd_addr  (cw_addr),
    .rd_size  (rd_size),
    .rd_data  (cw_data)
  );

  assign rd_idx = head_phys[gnt];

  sq_commit_port #(
    .LANES(LANES),
    .OFF_W(OFF_W)
  ) u_commit (
    .clk     (clk),
    .rst_n   (rst_n),
    .cand    (cand),
    .cw_ready(cw_ready),
    .sel_off (cw_addr[OFF_W-1:0]),
    .sel_size(rd_size),
    .gnt     (gnt),
    .cw_valid(cw_valid),
    .pop     (pop),
    .be      (cw_be)
  );

  assign cw_tid  = gnt;
  assign drained = mode_q ? empty : {empty[0], empty[0]};
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int DEPTH  = 56,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LANES = DATA_W / 8,
  localparam int HALF  = DEPTH / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              split_en,
  input logic              alloc_valid,
  input logic              alloc_tid,
  input logic              alloc_ready,
  input logic [IDX_W-1:0]  alloc_idx,
  input logic              cw_valid,
  input logic              cw_ready,
  input logic              cw_tid,
  input logic [ADDR_W-1:0] cw_addr,
  input logic [DATA_W-1:0] cw_data,
  input logic [LANES-1:0]  cw_be,
  input logic [1:0]        drained
);
  AST_CW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid && !cw_ready |=> cw_valid && $stable(cw_addr) && $stable(cw_data)
                              && $stable(cw_be) && $stable(cw_tid)); // R7

  AST_BE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |-> ($countones(cw_be) == 1) || ($countones(cw_be) == 2) ||
                 ($countones(cw_be) == 4) || ($countones(cw_be) == 8)); // R8

  AST_NO_COMMIT_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |-> !drained[cw_tid]); // R10

  AST_SPLIT_T1_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && alloc_ready && split_en && alloc_tid |-> alloc_idx >= IDX_W'(HALF)); // R9

  AST_SPLIT_T0_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && alloc_ready && split_en && !alloc_tid |-> alloc_idx < IDX_W'(HALF)); // R9

  AST_UNIFIED_TID: assert property (@(posedge clk) disable iff (!rst_n)
    !split_en && cw_valid |-> !cw_tid); // R9

  AST_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (split_en != $past(split_en)) |-> ($past(drained) == 2'b11)); // R12
endmodule

bind store_queue sq_checker #(
  .DEPTH (DEPTH),
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/store_queue_tb.sv
module store_queue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int HALF   = DEPTH / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic split_en = 1'b0;
  logic alloc_valid = 1'b0, alloc_tid = 1'b0, alloc_ready;
  logic [IDX_W-1:0] alloc_idx;
  logic addr_we = 1'b0;
  logic [IDX_W-1:0] addr_idx = '0;
  logic [ADDR_W-1:0] addr_val = '0;
  logic [1:0] addr_size = '0;
  logic data_we = 1'b0;
  logic [IDX_W-1:0] data_idx = '0;
  logic [DATA_W-1:0] data_val = '0;
  logic retire_valid = 1'b0, retire_tid = 1'b0;
  logic flush_valid = 1'b0, flush_tid = 1'b0;
  logic cw_valid, cw_ready = 1'b0, cw_tid;
  logic [ADDR_W-1:0] cw_addr;
  logic [DATA_W-1:0] cw_data;
  logic [7:0] cw_be;
  logic [1:0] drained;

  always #(CLK_PERIOD / 2) clk = ~clk;

  store_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (.*);

  int n_tests = 0, n_fail = 0, n_commit = 0;
  bit finished = 0;
  int p_alloc, p_ret, p_flush, p_ready, p_wr;

  // Reference model: per thread, slots by local ring position.
  logic [ADDR_W-1:0] m_a  [2][DEPTH];
  logic [1:0]        m_sz [2][DEPTH];
  logic [DATA_W-1:0] m_d  [2][DEPTH];
  bit                m_av [2][DEPTH];
  bit                m_dv [2][DEPTH];
  int head [2], len [2], nret [2];
  bit split = 0, prio = 0, held = 0;
  int hgnt = 0;

  function automatic int cap(input int t);
    return (t == 0 && !split) ? DEPTH : HALF;
  endfunction
  function automatic int base(input int t);
    return (t == 0) ? 0 : HALF;
  endfunction
  function automatic logic [7:0] exp_be(input logic [ADDR_W-1:0] a, input logic [1:0] sz);
    logic [15:0] w;
    w = 16'((1 << (1 << sz)) - 1) << a[2:0];
    return w[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input bit f_ret, input bit f_fl);
    int t, k, pos, g, ta, tr, tf, aw_t, aw_pos, dw_t, dw_pos;
    bit exp_rdy, exp_v, aw, dw;
    bit [1:0] cand;
    logic [1:0] exp_dr;
    @(negedge clk);
    alloc_valid  = ($urandom % 100) < p_alloc;
    alloc_tid    = 1'($urandom);
    retire_valid = f_ret || (($urandom % 100) < p_ret);
    retire_tid   = 1'($urandom);
    flush_valid  = f_fl || (($urandom % 100) < p_flush);
    flush_tid    = 1'($urandom);
    cw_ready     = ($urandom % 100) < p_ready;
    aw = 0; dw = 0; aw_t = 0; aw_pos = 0; dw_t = 0; dw_pos = 0;
    addr_we = 1'b0; data_we = 1'b0;
    if (($urandom % 100) < p_wr) begin
      t = split ? int'($urandom % 2) : 0;
      if (len[t] > 0) begin
        k = int'($urandom % len[t]);
        pos = (head[t] + k) % cap(t);
        if (!m_av[t][pos]) begin
          aw = 1; aw_t = t; aw_pos = pos;
          addr_we = 1'b1; addr_idx = IDX_W'(base(t) + pos);
          addr_size = 2'($urandom);
          addr_val = $urandom & ~((32'd1 << addr_size) - 1);
        end
      end
    end
    if (($urandom % 100) < p_wr) begin
      t = split ? int'($urandom % 2) : 0;
      if (len[t] > 0) begin
        k = int'($urandom % len[t]);
        pos = (head[t] + k) % cap(t);
        if (!m_dv[t][pos]) begin
          dw = 1; dw_t = t; dw_pos = pos;
          data_we = 1'b1; data_idx = IDX_W'(base(t) + pos);
          data_val = {$urandom, $urandom};
        end
      end
    end
    #1;
    ta = split ? int'(alloc_tid) : 0;
    tr = split ? int'(retire_tid) : 0;
    tf = split ? int'(flush_tid) : 0;
    exp_rdy = (len[ta] < cap(ta)) && !(flush_valid && tf == ta);
    chk(alloc_ready == exp_rdy, "R2 alloc_ready", 64'(alloc_ready), 64'(exp_rdy));
    if (alloc_valid && exp_rdy)
      chk(alloc_idx == IDX_W'(base(ta) + (head[ta] + len[ta]) % cap(ta)),
          split ? "R9 alloc_idx" : "R1 alloc_idx", 64'(alloc_idx),
          64'(base(ta) + (head[ta] + len[ta]) % cap(ta)));
    for (int i = 0; i < 2; i++)
      cand[i] = (i == 0 || split) && nret[i] > 0 &&
                m_av[i][head[i]] && m_dv[i][head[i]];
    if (held) g = hgnt;
    else      g = cand[prio] ? int'(prio) : int'(!prio);
    exp_v = cand[g];
    chk(cw_valid == exp_v, "R4 cw_valid", 64'(cw_valid), 64'(exp_v));
    if (exp_v && cw_valid) begin
      chk(cw_tid == 1'(g), "R11 cw_tid", 64'(cw_tid), 64'(g));
      chk(cw_addr == m_a[g][head[g]], held ? "R7 cw_addr held" : "R3 cw_addr",
          64'(cw_addr), 64'(m_a[g][head[g]]));
      chk(cw_data == m_d[g][head[g]], held ? "R7 cw_data held" : "R3 cw_data",
          cw_data, m_d[g][head[g]]);
      chk(cw_be == exp_be(m_a[g][head[g]], m_sz[g][head[g]]), "R8 cw_be",
          64'(cw_be), 64'(exp_be(m_a[g][head[g]], m_sz[g][head[g]])));
    end
    exp_dr = split ? {len[1] == 0, len[0] == 0} : {len[0] == 0, len[0] == 0};
    chk(drained == exp_dr, "R10 drained", 64'(drained), 64'(exp_dr));
    // model update for the coming edge
    if (exp_v && cw_ready) begin
      head[g] = (head[g] + 1) % cap(g); len[g]--; nret[g]--; n_commit++;
    end
    if (aw) begin
      m_av[aw_t][aw_pos] = 1; m_a[aw_t][aw_pos] = addr_val; m_sz[aw_t][aw_pos] = addr_size;
    end
    if (dw) begin
      m_dv[dw_t][dw_pos] = 1; m_d[dw_t][dw_pos] = data_val;
    end
    if (retire_valid && nret[tr] < len[tr]) nret[tr]++;
    if (flush_valid) len[tf] = nret[tf];
    if (alloc_valid && exp_rdy) begin
      pos = (head[ta] + len[ta]) % cap(ta);
      m_av[ta][pos] = 0; m_dv[ta][pos] = 0; len[ta]++;
    end
    held = exp_v && !cw_ready;
    hgnt = g;
    if (exp_v && cw_ready) prio = (g == 0);
  endtask

  task automatic knobs(input int a, input int r, input int f, input int rd, input int w);
    p_alloc = a; p_ret = r; p_flush = f; p_ready = rd; p_wr = w;
  endtask

  task automatic drain();
    knobs(0, 100, 0, 100, 100);
    for (int i = 0; i < 300 && (len[0] + len[1]) > 0; i++) step(0, 0);
    step(0, 0);
    chk(drained == 2'b11, "R10 drained after drain", 64'(drained), 64'h3);
  endtask

  task automatic switch_mode();
    @(negedge clk);
    split_en = ~split_en;
    alloc_valid = 1'b1; retire_valid = 1'b0; flush_valid = 1'b0;
    addr_we = 1'b0; data_we = 1'b0;
    #1;
    chk(alloc_ready == 1'b0, "R12 alloc refused on mode change", 64'(alloc_ready), 64'h0);
    split = split_en;
    for (int i = 0; i < 2; i++) begin head[i] = 0; len[i] = 0; nret[i] = 0; end
    held = 0;
  endtask

  initial begin
    int c0;
    void'($urandom(32'h5A17));
    for (int i = 0; i < 2; i++) begin head[i] = 0; len[i] = 0; nret[i] = 0; end
    knobs(0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(alloc_ready == 1'b1, "R2 ready after reset", 64'(alloc_ready), 64'h1);
    chk(cw_valid == 1'b0, "R4 idle after reset", 64'(cw_valid), 64'h0);
    chk(drained == 2'b11, "R10 drained after reset", 64'(drained), 64'h3);

    // Fill the whole unified ring: ready must drop at DEPTH stores (R2).
    knobs(100, 0, 0, 0, 0);
    repeat (DEPTH + 2) step(0, 0);
    chk(alloc_ready == 1'b0, "R2 full ring", 64'(alloc_ready), 64'h0);
    drain();

    // Retire with nothing speculative is ignored (R5).
    knobs(0, 0, 0, 100, 0);
    step(1, 0);
    knobs(100, 0, 0, 100, 0);
    step(0, 0);
    knobs(0, 0, 0, 100, 100);
    repeat (4) step(0, 0);
    chk(cw_valid == 1'b0 && drained == 2'b00, "R5 retire on empty ignored",
        64'({cw_valid, drained}), 64'h0);
    knobs(0, 0, 0, 100, 0);
    step(0, 1);
    step(0, 0);
    chk(drained == 2'b11, "R6 flush drops speculative store", 64'(drained), 64'h3);

    // Retired store survives a flush, younger ones do not (R6).
    knobs(100, 0, 0, 0, 0);
    repeat (3) step(0, 0);
    knobs(0, 0, 0, 0, 100);
    repeat (8) step(0, 0);
    knobs(0, 0, 0, 0, 0);
    step(1, 0);
    step(0, 1);
    c0 = n_commit;
    knobs(0, 0, 0, 100, 0);
    repeat (4) step(0, 0);
    chk(n_commit - c0 == 1 && drained == 2'b11, "R6 retired store kept",
        64'(n_commit - c0), 64'h1);

    // Random traffic, unified then split then unified.
    knobs(60, 40, 5, 60, 70);
    repeat (3000) step(0, 0);
    drain();
    switch_mode();
    knobs(60, 40, 5, 60, 70);
    repeat (3000) step(0, 0);
    knobs(90, 10, 0, 30, 70);
    repeat (500) step(0, 0);
    drain();
    switch_mode();
    knobs(60, 40, 5, 60, 70);
    repeat (500) step(0, 0);
    drain();

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule